// File: doc/BRIEF.md
# Pipeline Stage Handshake Register

This block sits between two neighbouring stages of a strictly in-order CPU pipeline. Each clock it can take one packet from the stage before it: a 32-bit instruction word, a payload whose width is a parameter, and a valid bit. It presents the packet it has registered to the stage after it. The downstream stage pushes back by raising a stall line, which is the inverse of ready. This register passes that stall on to its own upstream neighbour, so one stalled stage halts everything behind it. A flush input kills the registered packet in a single edge. The packet then travels on as a bubble.

Back-pressure follows valid/ready rules with ready = !stall. An upstream packet is taken at a rising edge when `up_stall` is low and `flush` is low. The upstream stage must keep its packet steady while `up_stall` is high. The downstream stage takes the presented packet at an edge where `dn_stall` is low. A packet counts as a bubble when its valid bit is low, or when its instruction is the canonical no-op word 0x00000013, whatever the valid bit says. A held bubble never pushes back: while the register holds one, `up_stall` stays low and the bubble is overwritten.

Top module: `pipe_stage_reg`

## Requirements
- R1: While `rst_n` is low at a rising edge, the register is cleared: `dn_valid` = 0, `dn_instr` = 0x00000013, `dn_payload` = 0.
- R2: At an edge where `up_stall` = 0 and `flush` = 0, the register loads `up_valid`, `up_instr` and `up_payload`. They appear on `dn_valid`, `dn_instr` and `dn_payload` after that edge.
- R3: At an edge where `dn_stall` = 1, `flush` = 0 and the held packet is not a bubble, `dn_valid`, `dn_instr` and `dn_payload` keep their values.
- R4: `dn_bubble` is 1 exactly when `dn_valid` = 0 or `dn_instr` = 0x00000013.
- R5: `up_stall` equals `dn_stall` while the held packet is not a bubble, and is 0 while it is a bubble.
- R6: At an edge where `dn_stall` = 1 and the held packet is a bubble, the register still loads the upstream packet.
- R7: At an edge where `flush` = 1, `dn_valid` becomes 0 whatever `dn_stall` is, and the upstream packet of that edge is discarded.
- R8: With `SCRUB_ON_FLUSH` = 1 (the default), a flush also sets `dn_instr` to 0x00000013 and leaves `dn_payload` unchanged.
- R9: Under any mix of valid, stall and flush, every accepted non-no-op packet leaves downstream exactly once and in order, unless a flush kills it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| up_valid | input | 1 | Upstream packet valid |
| up_instr | input | 32 | Upstream instruction word |
| up_payload | input | PAYLOAD_W | Upstream side-band payload |
| up_stall | output | 1 | Stall (not ready) returned to the upstream stage |
| flush | input | 1 | Kill the registered packet this edge |
| dn_stall | input | 1 | Stall (not ready) from the downstream stage |
| dn_valid | output | 1 | Registered packet valid |
| dn_instr | output | 32 | Registered instruction word |
| dn_payload | output | PAYLOAD_W | Registered payload |
| dn_bubble | output | 1 | Registered packet is a bubble |

## Verification
The bench goes after five corner cases. The first is a valid no-op packet held under stall. A design that trusted the valid bit alone would push back and freeze the pipeline behind a packet that does nothing. The second is a flush that arrives while the stage is stalled. If stall took priority over flush, the dead packet would survive and later retire as real work. The third is a flush with a live upstream packet. A design that let the load win would pass a wrong-path instruction downstream. A long run mixes valid, stall and flush patterns and tracks sequence numbers in the payload. It catches the other two failures: a hold path that drops a packet when stall is released, and a load path that repeats one.

// File: rtl/pipe_stage_pkg.sv
package pipe_stage_pkg;

  localparam int unsigned INSTR_W = 32;

  // Canonical no-op: add-immediate of zero into the zero register.
  localparam logic [INSTR_W-1:0] NOP_WORD = 32'h0000_0013;

  typedef logic [INSTR_W-1:0] instr_t;

  // What the storage does at the next edge.
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_LOAD = 2'd1,
    ACT_KILL = 2'd2
  } stage_act_e;

endpackage

// File: rtl/psr_bubble_detect.sv
module psr_bubble_detect
  import pipe_stage_pkg::*;
(
  input  logic   pkt_valid,
  input  instr_t pkt_instr,
  output logic   pkt_bubble
);

  logic is_noop;

  assign is_noop    = (pkt_instr == NOP_WORD);
  assign pkt_bubble = !pkt_valid || is_noop;

endmodule

// File: rtl/psr_ctrl.sv
module psr_ctrl
  import pipe_stage_pkg::*;
(
  input  logic       dn_stall,
  input  logic       flush,
  input  logic       held_bubble,
  output logic       up_stall,
  output stage_act_e act
);

  // A held bubble is never worth waiting for: let it be overwritten.
  assign up_stall = dn_stall && !held_bubble;

  always_comb begin
    if (flush)         act = ACT_KILL;
    else if (up_stall) act = ACT_HOLD;
    else               act = ACT_LOAD;
  end

endmodule

// File: rtl/psr_data_reg.sv
module psr_data_reg
  import pipe_stage_pkg::*;
#(
  parameter int unsigned PAYLOAD_W      = 32,
  parameter bit          SCRUB_ON_FLUSH = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  stage_act_e           act,
  input  logic                 in_valid,
  input  instr_t               in_instr,
  input  logic [PAYLOAD_W-1:0] in_payload,
  output logic                 q_valid,
  output instr_t               q_instr,
  output logic [PAYLOAD_W-1:0] q_payload
);

  instr_t kill_instr;

  generate
    if (SCRUB_ON_FLUSH) begin : g_scrub
      assign kill_instr = NOP_WORD;
    end else begin : g_keep
      assign kill_instr = q_instr;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid   <= 1'b0;
      q_instr   <= NOP_WORD;
      q_payload <= '0;
    end else begin
      unique case (act)
        ACT_LOAD: begin
          q_valid   <= in_valid;
          q_instr   <= in_instr;
          q_payload <= in_payload;
        end
        ACT_KILL: begin
          q_valid <= 1'b0;
          q_instr <= kill_instr;
        end
        default: begin
          q_valid   <= q_valid;
          q_instr   <= q_instr;
          q_payload <= q_payload;
        end
      endcase
    end
  end

endmodule

// File: rtl/pipe_stage_reg.sv
module pipe_stage_reg
  import pipe_stage_pkg::*;
#(
  parameter int unsigned PAYLOAD_W      = 32,
  parameter bit          SCRUB_ON_FLUSH = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 up_valid,
  input  logic [31:0]          up_instr,
  input  logic [PAYLOAD_W-1:0] up_payload,
  output logic                 up_stall,
  input  logic                 flush,
  input  logic                 dn_stall,
  output logic                 dn_valid,
  output logic [31:0]          dn_instr,
  output logic [PAYLOAD_W-1:0] dn_payload,
  output logic                 dn_bubble
);

  stage_act_e act;
  logic       held_bubble;

  psr_ctrl u_ctrl (
    .dn_stall    (dn_stall),
    .flush       (flush),
    .held_bubble (held_bubble),
    .up_stall    (up_stall),
    .act         (act)
  );

  psr_data_reg #(
    .PAYLOAD_W      (PAYLOAD_W),
    .SCRUB_ON_FLUSH (SCRUB_ON_FLUSH)
  ) u_data (
    .clk        (clk),
    .rst_n      (rst_n),
    .act        (act),
    .in_valid   (up_valid),
    .in_instr   (up_instr),
    .in_payload (up_payload),
    .q_valid    (dn_valid),
    .q_instr    (dn_instr),
    .q_payload  (dn_payload)
  );

  psr_bubble_detect u_bub (
    .pkt_valid  (dn_valid),
    .pkt_instr  (dn_instr),
    .pkt_bubble (held_bubble)
  );

  assign dn_bubble = held_bubble;

endmodule

// File: rtl/pipe_stage_reg_checker.sv
module pipe_stage_reg_checker #(
  parameter int unsigned PAYLOAD_W      = 32,
  parameter bit          SCRUB_ON_FLUSH = 1'b1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 up_valid,
  input logic [31:0]          up_instr,
  input logic [PAYLOAD_W-1:0] up_payload,
  input logic                 up_stall,
  input logic                 flush,
  input logic                 dn_stall,
  input logic                 dn_valid,
  input logic [31:0]          dn_instr,
  input logic [PAYLOAD_W-1:0] dn_payload,
  input logic                 dn_bubble
);

  localparam logic [31:0] NOP_CHK = 32'h0000_0013;

  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!up_stall && !flush) |=> (dn_valid == $past(up_valid) &&
      dn_instr == $past(up_instr) && dn_payload == $past(up_payload)));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_stall && !dn_bubble && !flush) |=>
      ($stable(dn_valid) && $stable(dn_instr) && $stable(dn_payload)));

  p_bubble_invalid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !dn_valid |-> dn_bubble);

  p_bubble_noop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_instr == NOP_CHK) |-> dn_bubble);

  p_bubble_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && dn_instr != NOP_CHK) |-> !dn_bubble);

  p_stall_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_stall && !dn_bubble) |-> up_stall);

  p_stall_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dn_bubble |-> !up_stall);

  p_stall_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    up_stall |-> dn_stall);

  p_overwrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_stall && dn_bubble && !flush) |=>
      (dn_valid == $past(up_valid) && dn_instr == $past(up_instr)));

  p_flush_kill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !dn_valid);

  generate
    if (SCRUB_ON_FLUSH) begin : g_scrub_chk
      p_flush_scrub_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (dn_instr == NOP_CHK && $stable(dn_payload)));
    end
  endgenerate

endmodule

bind pipe_stage_reg pipe_stage_reg_checker #(
  .PAYLOAD_W      (PAYLOAD_W),
  .SCRUB_ON_FLUSH (SCRUB_ON_FLUSH)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .up_valid   (up_valid),
  .up_instr   (up_instr),
  .up_payload (up_payload),
  .up_stall   (up_stall),
  .flush      (flush),
  .dn_stall   (dn_stall),
  .dn_valid   (dn_valid),
  .dn_instr   (dn_instr),
  .dn_payload (dn_payload),
  .dn_bubble  (dn_bubble)
);

// File: tb/pipe_stage_reg_tb.sv
module pipe_stage_reg_tb;

  localparam int          PW  = 32;
  localparam logic [31:0] NOP = 32'h0000_0013;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          up_valid = 1'b0;
  logic [31:0]   up_instr = 32'h0;
  logic [PW-1:0] up_payload = '0;
  logic          up_stall;
  logic          flush = 1'b0;
  logic          dn_stall = 1'b0;
  logic          dn_valid;
  logic [31:0]   dn_instr;
  logic [PW-1:0] dn_payload;
  logic          dn_bubble;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  pipe_stage_reg #(.PAYLOAD_W(PW)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .up_valid   (up_valid),
    .up_instr   (up_instr),
    .up_payload (up_payload),
    .up_stall   (up_stall),
    .flush      (flush),
    .dn_stall   (dn_stall),
    .dn_valid   (dn_valid),
    .dn_instr   (dn_instr),
    .dn_payload (dn_payload),
    .dn_bubble  (dn_bubble)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [31:0] ins,
                       input logic [PW-1:0] pay, input logic ds, input logic fl);
    up_valid = v; up_instr = ins; up_payload = pay; dn_stall = ds; flush = fl;
    #1;
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    drive(1'b1, 32'hDEAD_BEEF, 32'h55, 1'b1, 1'b0);
    tick(); tick();
    chk(dn_valid == 1'b0, "R1 valid", dn_valid, 0);
    chk(dn_instr == NOP, "R1 instr", dn_instr, NOP);
    chk(dn_payload == '0, "R1 payload", dn_payload, 0);
    chk(dn_bubble == 1'b1, "R4 reset bubble", dn_bubble, 1);
    chk(up_stall == 1'b0, "R5 bubble no stall", up_stall, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_capture();
    drive(1'b1, 32'h0000_0A01, 32'h1, 1'b0, 1'b0);
    tick();
    chk(dn_valid == 1'b1, "R2 valid", dn_valid, 1);
    chk(dn_instr == 32'h0000_0A01, "R2 instr", dn_instr, 32'hA01);
    chk(dn_payload == 32'h1, "R2 payload", dn_payload, 1);
    chk(dn_bubble == 1'b0, "R4 live", dn_bubble, 0);
    drive(1'b0, 32'h0000_0B02, 32'h2, 1'b0, 1'b0);
    tick();
    chk(dn_valid == 1'b0, "R2 invalid load", dn_valid, 0);
    chk(dn_bubble == 1'b1, "R4 invalid bubble", dn_bubble, 1);
  endtask

  task automatic t_hold();
    drive(1'b1, 32'h0000_0C03, 32'h3, 1'b0, 1'b0);
    tick();
    drive(1'b1, 32'h0000_0D04, 32'h4, 1'b1, 1'b0);
    chk(up_stall == 1'b1, "R5 pass stall", up_stall, 1);
    for (int i = 0; i < 2; i++) begin
      tick();
      chk(dn_instr == 32'h0000_0C03, "R3 hold instr", dn_instr, 32'hC03);
      chk(dn_payload == 32'h3, "R3 hold payload", dn_payload, 3);
      chk(dn_valid == 1'b1, "R3 hold valid", dn_valid, 1);
    end
    drive(1'b1, 32'h0000_0D04, 32'h4, 1'b0, 1'b0);
    chk(up_stall == 1'b0, "R5 release", up_stall, 0);
    tick();
    chk(dn_instr == 32'h0000_0D04, "R2 after release", dn_instr, 32'hD04);
  endtask

  task automatic t_noop_bubble();
    drive(1'b1, NOP, 32'h7, 1'b0, 1'b0);
    tick();
    chk(dn_valid == 1'b1 && dn_bubble == 1'b1, "R4 valid noop is bubble",
        {dn_valid, dn_bubble}, 2'b11);
    drive(1'b1, 32'h0000_0E05, 32'h5, 1'b1, 1'b0);
    chk(up_stall == 1'b0, "R5 noop no stall", up_stall, 0);
    tick();
    chk(dn_instr == 32'h0000_0E05, "R6 overwrite instr", dn_instr, 32'hE05);
    chk(dn_valid == 1'b1, "R6 overwrite valid", dn_valid, 1);
  endtask

  task automatic t_flush();
    // Flush while stalled on a live packet.
    drive(1'b1, 32'h0000_0F06, 32'h6, 1'b0, 1'b0);
    tick();
    drive(1'b1, 32'h0000_1007, 32'h8, 1'b1, 1'b1);
    tick();
    chk(dn_valid == 1'b0, "R7 flush under stall", dn_valid, 0);
    chk(dn_instr == NOP, "R8 scrub instr", dn_instr, NOP);
    chk(dn_payload == 32'h6, "R8 payload kept", dn_payload, 6);
    // Flush while flowing: upstream packet is discarded.
    drive(1'b1, 32'h0000_1108, 32'h9, 1'b0, 1'b0);
    tick();
    drive(1'b1, 32'h0000_1209, 32'hA, 1'b0, 1'b1);
    tick();
    chk(dn_valid == 1'b0, "R7 flush drops upstream", dn_valid, 0);
    chk(dn_instr == NOP, "R7 upstream not taken", dn_instr, NOP);
    drive(1'b0, 32'h0, 32'h0, 1'b0, 1'b0);
    tick();
  endtask

  task automatic t_random();
    logic [15:0] lfsr = 16'hACE1;
    int seq = 1;
    int last = 0;
    int n_acc = 0;
    int n_del = 0;
    int n_kill = 0;
    bit pend_flush = 1'b0;
    for (int c = 0; c < 3000; c++) begin
      for (int s = 0; s < 8; s++)
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      drive(lfsr[0] | lfsr[1], 32'h1000_0000 | seq, seq,
            lfsr[2], (lfsr[7:4] == 4'h0));
      if (pend_flush)
        chk(dn_valid == 1'b0, "R7 random flush", dn_valid, 0);
      if (flush && dn_valid && !dn_bubble) n_kill++;
      if (dn_valid && !dn_bubble && !dn_stall && !flush) begin
        n_del++;
        chk(int'(dn_payload) > last, "R9 order/dup", dn_payload, last + 1);
        last = int'(dn_payload);
      end
      if (up_valid && !up_stall && !flush) begin
        n_acc++;
        seq++;
      end
      pend_flush = flush;
      tick();
    end
    for (int c = 0; c < 3; c++) begin
      drive(1'b0, 32'h0, 32'h0, 1'b0, 1'b0);
      if (dn_valid && !dn_bubble) n_del++;
      tick();
    end
    chk(n_acc == n_del + n_kill, "R9 balance", n_del + n_kill, n_acc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_capture();
    t_hold();
    t_noop_bubble();
    t_flush();
    t_random();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule